// File: doc/BRIEF.md
# Serial PHY register access port

This block is a small memory-mapped bridge between a host bus and the register port of a serial transceiver. The host never talks to the transceiver directly. It first loads a data word into a staging register. It then writes a command word that holds a write flag, a rate selector, a lane mask and an 8-bit transceiver register address. The bridge latches these fields, raises a level request on the PHY-side port and waits for the PHY to answer. When the answer arrives, it sets an acknowledge bit that the host polls.

Every access has two phases. The host issues the command and waits for the acknowledge. It then writes zero to the command register and waits for the acknowledge again, while the bridge withdraws its request and waits for the PHY to drop its answer. If the PHY stays silent for longer than a programmable number of cycles, the bridge withdraws the request and sets a sticky timeout flag, which lets the host recover.

Host register map (word index on `hostAddr`): 0 is the staging data register, 1 is the command register, 2 is status, 3 is the timeout limit. The command word places the write flag at bit 31, the rate at bit 24, the lane mask at bits 19:16, the transceiver register address at bits 15:8 and, on read, the acknowledge at bit 0. Status places the sticky timeout at bit 0 and busy at bit 1.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the data, command and status registers read zero, the limit register reads DEFAULT_LIMIT, and phyReq is low.
- R2: A command written with bit 31 set while no request is held raises phyReq on the next cycle. phyRate carries bit 24, phyLaneMask bits 19:16, phyAddr bits 15:8 and phyWrData the staging data register. All of them stay stable while phyReq is high.
- R3: Acknowledge (command bit 0) goes high the cycle after phyAck is seen high during a request. Any accepted command write clears it on the following edge.
- R4: A command written with bit 31 clear while a request is held drops phyReq on the next cycle. Acknowledge rises the cycle after phyAck is seen low.
- R5: A command written with bit 31 clear while no request is held is acknowledged exactly two edges after the write, and phyReq stays low.
- R6: Status bit 1 (busy) is high while a handshake is pending. Command writes during busy are ignored. A command with bit 31 set is also ignored while the previous request has not been cleared. An ignored write leaves the command register and acknowledge unchanged.
- R7: If the PHY does not answer within the limit register's cycle count of waiting, status bit 0 sets, phyReq is withdrawn, busy ends and acknowledge stays low.
- R8: The timeout flag stays set until the host writes status with bit 0 set. A status write with bit 0 clear leaves it set.
- R9: The data and limit registers read back what was written. The command register reads back the written word with bit 0 replaced by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostAddr | input | 2 | Host register word index |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data for the register selected by hostAddr |
| phyReq | output | 1 | Level request towards the PHY register port |
| phyRate | output | 1 | Rate selector of the current write |
| phyLaneMask | output | 4 | Lanes that receive the write |
| phyAddr | output | 8 | PHY register address |
| phyWrData | output | 32 | PHY write data |
| phyAck | input | 1 | PHY answer; follows phyReq once the access is done |

## Verification
Corrupt sequencer state shows up as a request level that no longer matches the last accepted command. It also shows up as an acknowledge that never arrives or arrives early, which a poller notices within one handshake. The scoreboard compares the latched fields at every rising phyReq, so a wrongly latched field or a wrongly accepted command is caught at that rising edge. The per-rate, per-lane PHY store catches a lost lane or rate bit at the end of the sequence. A broken timeout counter is caught by reading status just before and just after the programmed limit.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int WORD_W    = 32;
  localparam int HOST_AW   = 2;
  localparam int LANE_N    = 4;
  localparam int REGA_W    = 8;
  localparam int POS_WRITE = 31;
  localparam int POS_RATE  = 24;
  localparam int POS_LANE  = 16;
  localparam int POS_ADDR  = 8;

  localparam logic [HOST_AW-1:0] IDX_DATA  = 2'd0;
  localparam logic [HOST_AW-1:0] IDX_CMD   = 2'd1;
  localparam logic [HOST_AW-1:0] IDX_STAT  = 2'd2;
  localparam logic [HOST_AW-1:0] IDX_LIMIT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_REL,
    ST_ACK
  } seqState_t;

  typedef struct packed {
    logic acceptCmd;
    logic latchPhy;
    logic setAck;
    logic setTimeout;
  } seqStrobe_t;
endpackage

// File: rtl/prb_seq.sv
module prb_seq
  import prb_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrite,
  input  logic               writeFlag,
  input  logic               phyAck,
  input  logic [TIMER_W-1:0] limit,
  output seqStrobe_t         strb,
  output logic               phyReq,
  output logic               busy
);
  localparam int CMP_W = TIMER_W + 1;

  seqState_t state, nextState;
  logic reqLevel, nextReq;
  logic [TIMER_W-1:0] waitCnt;
  logic reach;

  assign reach  = ({1'b0, waitCnt} + CMP_W'(1)) >= {1'b0, limit};
  assign phyReq = reqLevel;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    nextReq   = reqLevel;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (cmdWrite) begin
          if (writeFlag) begin
            if (!reqLevel) begin
              strb.acceptCmd = 1'b1;
              strb.latchPhy  = 1'b1;
              nextReq        = 1'b1;
              nextState      = ST_REQ;
            end
          end else begin
            strb.acceptCmd = 1'b1;
            if (reqLevel) begin
              nextReq   = 1'b0;
              nextState = ST_REL;
            end else begin
              nextState = ST_ACK;
            end
          end
        end
      end
      ST_REQ: begin
        if (phyAck) begin
          strb.setAck = 1'b1;
          nextState   = ST_IDLE;
        end else if (reach) begin
          strb.setTimeout = 1'b1;
          nextReq         = 1'b0;
          nextState       = ST_IDLE;
        end
      end
      ST_REL: begin
        if (!phyAck) begin
          strb.setAck = 1'b1;
          nextState   = ST_IDLE;
        end else if (reach) begin
          strb.setTimeout = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      ST_ACK: begin
        strb.setAck = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqLevel <= 1'b0;
      waitCnt  <= '0;
    end else begin
      state    <= nextState;
      reqLevel <= nextReq;
      if (state == ST_IDLE) waitCnt <= '0;
      else                  waitCnt <= waitCnt + TIMER_W'(1);
    end
  end
endmodule

// File: rtl/prb_phyport.sv
module prb_phyport
  import prb_pkg::*;
#(
  parameter int LANES  = LANE_N,
  parameter int ADDR_W = REGA_W,
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latch,
  input  logic              rateIn,
  input  logic [LANES-1:0]  laneIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              rateOut,
  output logic [LANES-1:0]  laneOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)      laneOut[ln] <= 1'b0;
      else if (latch) laneOut[ln] <= laneIn[ln];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateOut <= 1'b0;
      addrOut <= '0;
      dataOut <= '0;
    end else if (latch) begin
      rateOut <= rateIn;
      addrOut <= addrIn;
      dataOut <= dataIn;
    end
  end
endmodule

// File: rtl/prb_regs.sv
module prb_regs
  import prb_pkg::*;
#(
  parameter int          TIMER_W       = 16,
  parameter logic [15:0] DEFAULT_LIMIT = 16'd4000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0]  hostWrData,
  output logic [WORD_W-1:0]  hostRdData,
  input  seqStrobe_t         strb,
  input  logic               busy,
  output logic               cmdWrite,
  output logic               writeFlag,
  output logic [TIMER_W-1:0] limit,
  output logic [WORD_W-1:0]  dataReg,
  output logic [WORD_W-1:1]  cmdWord,
  output logic               ackBit,
  output logic               toFlag
);
  logic statClr;

  assign cmdWrite  = hostWrEn && (hostAddr == IDX_CMD);
  assign writeFlag = hostWrData[POS_WRITE];
  assign statClr   = hostWrEn && (hostAddr == IDX_STAT) && hostWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      cmdWord <= '0;
      ackBit  <= 1'b0;
      toFlag  <= 1'b0;
      limit   <= TIMER_W'(DEFAULT_LIMIT);
    end else begin
      if (hostWrEn && hostAddr == IDX_DATA)  dataReg <= hostWrData;
      if (hostWrEn && hostAddr == IDX_LIMIT) limit   <= hostWrData[TIMER_W-1:0];
      if (strb.acceptCmd) begin
        cmdWord <= hostWrData[WORD_W-1:1];
        ackBit  <= 1'b0;
      end else if (strb.setAck) begin
        ackBit  <= 1'b1;
      end
      if (strb.setTimeout) toFlag <= 1'b1;
      else if (statClr)    toFlag <= 1'b0;
    end
  end

  always_comb begin
    case (hostAddr)
      IDX_DATA:  hostRdData = dataReg;
      IDX_CMD:   hostRdData = {cmdWord, ackBit};
      IDX_STAT:  hostRdData = {{(WORD_W-2){1'b0}}, busy, toFlag};
      default:   hostRdData = WORD_W'(limit);
    endcase
  end
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import prb_pkg::*;
#(
  parameter int          TIMER_W       = 16,
  parameter logic [15:0] DEFAULT_LIMIT = 16'd4000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWrEn,
  input  logic [HOST_AW-1:0]    hostAddr,
  input  logic [WORD_W-1:0]     hostWrData,
  output logic [WORD_W-1:0]     hostRdData,
  output logic                  phyReq,
  output logic                  phyRate,
  output logic [LANE_N-1:0]     phyLaneMask,
  output logic [REGA_W-1:0]     phyAddr,
  output logic [WORD_W-1:0]     phyWrData,
  input  logic                  phyAck
);
  seqStrobe_t         strb;
  logic               busy;
  logic               cmdWrite;
  logic               writeFlag;
  logic [TIMER_W-1:0] limit;
  logic [WORD_W-1:0]  dataReg;
  logic [WORD_W-1:1]  cmdWord;
  logic               ackBit;
  logic               toFlag;

  prb_regs #(
    .TIMER_W      (TIMER_W),
    .DEFAULT_LIMIT(DEFAULT_LIMIT)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .strb      (strb),
    .busy      (busy),
    .cmdWrite  (cmdWrite),
    .writeFlag (writeFlag),
    .limit     (limit),
    .dataReg   (dataReg),
    .cmdWord   (cmdWord),
    .ackBit    (ackBit),
    .toFlag    (toFlag)
  );

  prb_seq #(
    .TIMER_W(TIMER_W)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .writeFlag(writeFlag),
    .phyAck   (phyAck),
    .limit    (limit),
    .strb     (strb),
    .phyReq   (phyReq),
    .busy     (busy)
  );

  prb_phyport #(
    .LANES (LANE_N),
    .ADDR_W(REGA_W),
    .DATA_W(WORD_W)
  ) u_port (
    .clk    (clk),
    .rstN   (rstN),
    .latch  (strb.latchPhy),
    .rateIn (hostWrData[POS_RATE]),
    .laneIn (hostWrData[POS_LANE +: LANE_N]),
    .addrIn (hostWrData[POS_ADDR +: REGA_W]),
    .dataIn (dataReg),
    .rateOut(phyRate),
    .laneOut(phyLaneMask),
    .addrOut(phyAddr),
    .dataOut(phyWrData)
  );
endmodule

// File: rtl/prb_checker.sv
module prb_checker
  import prb_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cmdWrite,
  input logic               statClr,
  input logic               phyReq,
  input logic               phyAck,
  input logic               phyRate,
  input logic [LANE_N-1:0]  phyLaneMask,
  input logic [REGA_W-1:0]  phyAddr,
  input logic [WORD_W-1:0]  phyWrData,
  input logic               ackBit,
  input logic               busy,
  input logic               toFlag,
  input logic [WORD_W-1:1]  cmdWord
);
  // R2: request fields hold while the request stays up
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    phyReq |=> (!phyReq || ($stable(phyRate) && $stable(phyLaneMask) &&
                            $stable(phyAddr) && $stable(phyWrData))));

  // R3: a PHY answer during a pending request sets the acknowledge next
  a_r3_ack_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phyReq && phyAck) |=> ackBit);

  // R6: no acknowledge while a handshake is pending
  a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ackBit);

  // R6: command writes during busy leave the command register alone
  a_r6_busy_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite) |=> $stable(cmdWord));

  // R7: a fresh timeout coincides with a withdrawn request and idle sequencer
  a_r7_timeout_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> (!phyReq && !busy));

  // R8: the timeout flag holds until the host clears it
  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !statClr) |=> toFlag);
endmodule

bind phy_reg_bridge prb_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdWrite   (cmdWrite),
  .statClr    (hostWrEn && hostAddr == prb_pkg::IDX_STAT && hostWrData[0]),
  .phyReq     (phyReq),
  .phyAck     (phyAck),
  .phyRate    (phyRate),
  .phyLaneMask(phyLaneMask),
  .phyAddr    (phyAddr),
  .phyWrData  (phyWrData),
  .ackBit     (ackBit),
  .busy       (busy),
  .toFlag     (toFlag),
  .cmdWord    (cmdWord)
);

// File: tb/phy_reg_bridge_bench.sv
`timescale 1ns/1ps
module phy_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = 32'd0;
  logic [31:0] hostRdData;
  logic        phyReq;
  logic        phyRate;
  logic [3:0]  phyLaneMask;
  logic [7:0]  phyAddr;
  logic [31:0] phyWrData;
  logic        phyAck;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int phyDelay = 3;
  bit phyMute = 1'b0;
  int dly = 0;
  bit prevReq = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic       rate;
    logic [3:0] lane;
    logic [7:0] addr;
    logic [31:0] data;
  } exp_t;
  exp_t expQ[$];

  logic [31:0] phyMem [2][4][256];

  always #2.5 clk = ~clk;

  phy_reg_bridge u_phy_reg_bridge (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .phyReq(phyReq),
    .phyRate(phyRate), .phyLaneMask(phyLaneMask), .phyAddr(phyAddr),
    .phyWrData(phyWrData), .phyAck(phyAck)
  );

  // Behavioural PHY register port: one store per rate and lane
  always @(posedge clk) begin
    if (!rstN) begin
      phyAck <= 1'b0;
      dly    <= 0;
    end else if (phyReq != phyAck) begin
      if (!phyMute) begin
        if (dly >= phyDelay) begin
          phyAck <= phyReq;
          dly    <= 0;
          if (phyReq)
            for (int ln = 0; ln < 4; ln++)
              if (phyLaneMask[ln]) phyMem[phyRate][ln][phyAddr] <= phyWrData;
        end else begin
          dly <= dly + 1;
        end
      end
    end else begin
      dly <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Monitor: every rising request must match the oldest expected item (R2)
  always @(negedge clk) begin
    if (rstN && phyReq && !prevReq) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected request", {23'd0, phyRate, phyLaneMask, phyAddr}, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(phyRate == e.rate && phyLaneMask == e.lane && phyAddr == e.addr,
              "R2 request fields", {19'd0, phyRate, phyLaneMask, phyAddr},
              {19'd0, e.rate, e.lane, e.addr});
        check(phyWrData == e.data, "R2 request data", phyWrData, e.data);
      end
    end
    prevReq = phyReq;
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finishRun();
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  function automatic logic [31:0] mkCmd(input logic rate, input logic [3:0] lane, input logic [7:0] addr);
    return {1'b1, 6'd0, rate, 4'd0, lane, addr, 8'd0};
  endfunction

  task automatic pollAck(input string tag);
    logic [31:0] v;
    bit seen = 1'b0;
    for (int p = 0; p < 100 && !seen; p++) begin
      repeat (5) @(negedge clk);
      hostRead(2'd1, v);
      seen = v[0];
    end
    check(seen, tag, {31'd0, seen}, 32'd1);
  endtask

  // Driver: push expected item, then run the full two-phase access
  task automatic phyWrite(input logic rate, input logic [3:0] lane, input logic [7:0] addr, input logic [31:0] data);
    exp_t e;
    e.rate = rate; e.lane = lane; e.addr = addr; e.data = data;
    expQ.push_back(e);
    hostWrite(2'd0, data);
    hostWrite(2'd1, mkCmd(rate, lane, addr));
    pollAck("R3 write acknowledge");
    hostWrite(2'd0, 32'd0);
    hostWrite(2'd1, 32'd0);
    pollAck("R4 clear acknowledge");
  endtask

  initial begin
    logic [31:0] v;
    for (int r = 0; r < 2; r++)
      for (int ln = 0; ln < 4; ln++)
        for (int a = 0; a < 256; a++) phyMem[r][ln][a] = 32'd0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hostRead(2'd0, v); check(v == 32'd0, "R1 data reset", v, 32'd0);
    hostRead(2'd1, v); check(v == 32'd0, "R1 command reset", v, 32'd0);
    hostRead(2'd2, v); check(v == 32'd0, "R1 status reset", v, 32'd0);
    hostRead(2'd3, v); check(v == 32'd4000, "R1 limit reset", v, 32'd4000);
    check(phyReq == 1'b0, "R1 request low", {31'd0, phyReq}, 32'd0);

    // R9 readback
    hostWrite(2'd3, 32'd500);
    hostRead(2'd3, v); check(v == 32'd500, "R9 limit readback", v, 32'd500);
    hostWrite(2'd0, 32'hA5A5_0F0F);
    hostRead(2'd0, v); check(v == 32'hA5A5_0F0F, "R9 data readback", v, 32'hA5A5_0F0F);

    // R2 R3 R4: plain writes, both rates on the same address, multi-lane mask
    phyWrite(1'b0, 4'b0010, 8'h42, 32'h0EC3_4191);
    phyWrite(1'b1, 4'b0010, 8'h42, 32'h0EC3_4180);
    phyWrite(1'b0, 4'b1010, 8'h10, 32'h1234_5678);

    // R9 R3: command readback right after acceptance shows fields, ack low
    hostWrite(2'd0, 32'hCAFE_0001);
    expQ.push_back('{1'b1, 4'b0100, 8'h55, 32'hCAFE_0001});
    hostWrite(2'd1, mkCmd(1'b1, 4'b0100, 8'h55));
    hostRead(2'd1, v);
    check(v == mkCmd(1'b1, 4'b0100, 8'h55), "R9 R3 command readback ack low", v, mkCmd(1'b1, 4'b0100, 8'h55));
    pollAck("R3 acknowledge after answer");
    // R4: clear drops request on the next cycle
    hostWrite(2'd1, 32'd0);
    check(phyReq == 1'b0, "R4 request dropped", {31'd0, phyReq}, 32'd0);
    pollAck("R4 release acknowledge");

    // R5: clear with no request outstanding
    hostWrite(2'd1, 32'd0);
    hostRead(2'd1, v); check(v[0] == 1'b0, "R5 ack cleared after write", v, 32'd0);
    @(negedge clk);
    hostRead(2'd1, v); check(v == 32'd1, "R5 ack one cycle later", v, 32'd1);
    check(phyReq == 1'b0, "R5 request stays low", {31'd0, phyReq}, 32'd0);

    // R6: busy, writes during busy and unclear re-issue are ignored
    phyDelay = 12;
    hostWrite(2'd0, 32'h0000_BEEF);
    expQ.push_back('{1'b0, 4'b0001, 8'h66, 32'h0000_BEEF});
    hostWrite(2'd1, mkCmd(1'b0, 4'b0001, 8'h66));
    hostRead(2'd2, v); check(v == 32'd2, "R6 busy during handshake", v, 32'd2);
    hostWrite(2'd1, mkCmd(1'b1, 4'b1111, 8'h77));
    hostRead(2'd1, v);
    check(v == mkCmd(1'b0, 4'b0001, 8'h66), "R6 write during busy ignored", v, mkCmd(1'b0, 4'b0001, 8'h66));
    pollAck("R6 original access acknowledged");
    hostWrite(2'd1, mkCmd(1'b1, 4'b1111, 8'h77));
    hostRead(2'd1, v);
    check(v == (mkCmd(1'b0, 4'b0001, 8'h66) | 32'd1), "R6 re-issue without clear ignored", v, mkCmd(1'b0, 4'b0001, 8'h66) | 32'd1);
    hostRead(2'd2, v); check(v == 32'd0, "R6 not busy after ignored write", v, 32'd0);
    hostWrite(2'd1, 32'd0);
    pollAck("R6 clear acknowledge");
    phyDelay = 3;

    // R7: silent PHY, limit 20
    hostWrite(2'd3, 32'd20);
    phyMute = 1'b1;
    hostWrite(2'd0, 32'h0000_0BAD);
    expQ.push_back('{1'b0, 4'b1000, 8'h99, 32'h0000_0BAD});
    hostWrite(2'd1, mkCmd(1'b0, 4'b1000, 8'h99));
    repeat (15) @(negedge clk);
    hostRead(2'd2, v); check(v == 32'd2, "R7 no timeout before limit", v, 32'd2);
    repeat (10) @(negedge clk);
    hostRead(2'd2, v); check(v == 32'd1, "R7 timeout set busy clear", v, 32'd1);
    check(phyReq == 1'b0, "R7 request withdrawn", {31'd0, phyReq}, 32'd0);
    hostRead(2'd1, v); check(v[0] == 1'b0, "R7 ack stays low", v, 32'd0);
    phyMute = 1'b0;
    hostWrite(2'd1, 32'd0);
    pollAck("R7 recovery clear acknowledged");

    // R8: sticky until cleared with bit 0
    hostWrite(2'd2, 32'd0);
    hostRead(2'd2, v); check(v == 32'd1, "R8 write zero keeps flag", v, 32'd1);
    hostWrite(2'd2, 32'd1);
    hostRead(2'd2, v); check(v == 32'd0, "R8 write one clears flag", v, 32'd0);
    hostWrite(2'd3, 32'd500);

    // R2: PHY store holds separate values per rate and per lane
    check(phyMem[0][1][8'h42] == 32'h0EC3_4191, "R2 rate0 store", phyMem[0][1][8'h42], 32'h0EC3_4191);
    check(phyMem[1][1][8'h42] == 32'h0EC3_4180, "R2 rate1 store", phyMem[1][1][8'h42], 32'h0EC3_4180);
    check(phyMem[0][1][8'h10] == 32'h1234_5678, "R2 lane1 of mask", phyMem[0][1][8'h10], 32'h1234_5678);
    check(phyMem[0][3][8'h10] == 32'h1234_5678, "R2 lane3 of mask", phyMem[0][3][8'h10], 32'h1234_5678);
    check(phyMem[0][0][8'h10] == 32'd0, "R2 lane0 untouched", phyMem[0][0][8'h10], 32'd0);
    check(phyMem[1][3][8'h77] == 32'd0, "R6 ignored command wrote nothing", phyMem[1][3][8'h77], 32'd0);
    check(expQ.size() == 0, "R2 all expected requests seen", expQ.size(), 32'd0);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule